// File: doc/BRIEF.md
# Escape-Marker Byte Stuffing Codec

This block keeps two reserved byte values out of a debug response stream. It has two independent streaming paths that share a clock and a reset. The encoder path takes raw response bytes and produces an escaped stream in which the fill value never appears and the marker value appears only as the first byte of an escape pair. The decoder path takes such an escaped stream and recovers the raw bytes.

Each reserved data byte becomes two bytes on the wire: the marker 0x55, then the data byte XORed with 0x55. So 0xAA travels as 0x55 0xFF and 0x55 travels as 0x55 0x00. In the worst case the encoded stream is twice as long as the raw stream. Both paths move one byte per cycle on valid/ready handshakes, honour back-pressure, and carry a per-byte end-of-frame flag. The decoder discards bare 0xAA fill bytes, and it raises an error pulse when a frame ends on a dangling marker.

The asynchronous active-low reset is released through a small synchronizer, so both paths leave reset on a clock edge.

Top module: `stuff_codec`

## Requirements
- R1: A few cycles after `arst_n` rises, both output valids and `dec_err` are low and both input readies are high.
- R2: The encoder emits a byte other than 0x55 or 0xAA once, unchanged, with its end-of-frame flag.
- R3: The encoder emits a data byte of 0x55 or 0xAA as 0x55 followed by the byte XOR 0x55. The first byte carries last=0 and the second carries the input's end-of-frame flag.
- R4: In the cycle after the encoder accepts a reserved byte, `enc_in_ready` is low. 0xAA never appears as valid encoder output.
- R5: With the sink always ready, a burst of N back-to-back reserved bytes leaves the encoder as 2N bytes on 2N consecutive cycles.
- R6: When the decoder sees 0x55 in plain state it outputs nothing for it, then outputs the next byte XOR 0x55 with that byte's end-of-frame flag. For example, 55 FF gives AA, 55 00 gives 55, and 55 AA gives FF.
- R7: The decoder passes a byte other than 0x55 or 0xAA, seen in plain state, through unchanged with its end-of-frame flag.
- R8: The decoder drops a bare 0xAA seen in plain state, even one flagged as end-of-frame, and outputs nothing for it.
- R9: A 0x55 in plain state flagged as end-of-frame produces no output and a one-cycle `dec_err` pulse. The decoder then returns to plain state.
- R10: While an output valid is high and its ready is low, the data and last flag of that output hold. No byte is lost or duplicated under back-pressure.
- R11: Feeding the encoder output into the decoder gives back every byte value 0..255 in order, with its frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_in_valid | input | 1 | Raw byte offered to encoder |
| enc_in_ready | output | 1 | Encoder accepts raw byte |
| enc_in_data | input | 8 | Raw byte |
| enc_in_last | input | 1 | Raw byte ends a frame |
| enc_out_valid | output | 1 | Encoded byte available |
| enc_out_ready | input | 1 | Sink takes encoded byte |
| enc_out_data | output | 8 | Encoded byte |
| enc_out_last | output | 1 | Encoded byte ends a frame |
| dec_in_valid | input | 1 | Escaped byte offered to decoder |
| dec_in_ready | output | 1 | Decoder accepts escaped byte |
| dec_in_data | input | 8 | Escaped byte |
| dec_in_last | input | 1 | Escaped byte ends a frame |
| dec_out_valid | output | 1 | Recovered byte available |
| dec_out_ready | input | 1 | Sink takes recovered byte |
| dec_out_data | output | 8 | Recovered byte |
| dec_out_last | output | 1 | Recovered byte ends a frame |
| dec_err | output | 1 | One-cycle pulse: frame ended on a dangling marker |

## Verification
The assertions check several properties on every cycle:
- Held outputs stay stable under back-pressure, and no load overwrites a held byte.
- Accepting a reserved byte is followed by a marker on the output and by a ready bubble.
- 0xAA never leaves the encoder.
- A dropped marker or fill byte leaves the decoder output empty.
- An error pulse never coincides with output data.

Only the bench's scenarios can show the full byte-for-byte mapping and end-to-end behaviour. These scenarios are exhaustive sweeps of all 256 values through the encoder, with the sink always ready and with the sink throttled, plus a loopback round trip. They also cover the two-bytes-per-cycle-pair throughput of a reserved burst and the exact decoder sequences for escapes, fill and a frame that ends on a marker.

// File: rtl/stuff_pkg.sv
package stuff_pkg;
  localparam logic [7:0] MARKER_DEF = 8'h55;
  localparam logic [7:0] FILL_DEF   = 8'hAA;

  typedef enum logic {
    ENC_DIRECT,
    ENC_SECOND
  } enc_phase_e;

  typedef enum logic {
    DEC_PLAIN,
    DEC_ESCAPED
  } dec_phase_e;
endpackage

// File: rtl/rst_release.sv
module rst_release #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/beat_hold.sv
module beat_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         load_last,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         last_o,
  output logic         free_o
);
  logic valid_d;

  assign free_o = !valid_o || ready_i;

  always_comb begin
    valid_d = valid_o;
    if (load)         valid_d = 1'b1;
    else if (ready_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      last_o <= 1'b0;
    end else if (load) begin
      data_o <= load_data;
      last_o <= load_last;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(last_o));

  // R10
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free_o);
endmodule

// File: rtl/escape_encoder.sv
module escape_encoder
  import stuff_pkg::*;
#(
  parameter int unsigned     W      = 8,
  parameter logic [W-1:0]    MARKER = MARKER_DEF,
  parameter logic [W-1:0]    FILL   = FILL_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_last
);
  enc_phase_e   phase_q, phase_d;
  logic [W-1:0] pend_data_q;
  logic         pend_last_q;
  logic         slot_free, in_fire, reserved, load;
  logic [W-1:0] load_data;
  logic         load_last;

  assign reserved = (in_data == MARKER) || (in_data == FILL);
  assign in_ready = (phase_q == ENC_DIRECT) && slot_free;
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    load      = 1'b0;
    load_data = in_data;
    load_last = in_last;
    phase_d   = phase_q;
    if (phase_q == ENC_SECOND) begin
      if (slot_free) begin
        load      = 1'b1;
        load_data = pend_data_q;
        load_last = pend_last_q;
        phase_d   = ENC_DIRECT;
      end
    end else if (in_fire) begin
      load = 1'b1;
      if (reserved) begin
        load_data = MARKER;
        load_last = 1'b0;
        phase_d   = ENC_SECOND;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= ENC_DIRECT;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_data_q <= '0;
      pend_last_q <= 1'b0;
    end else if (in_fire && reserved) begin
      pend_data_q <= in_data ^ MARKER;
      pend_last_q <= in_last;
    end
  end

  beat_hold #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .load_last (load_last),
    .ready_i   (out_ready),
    .valid_o   (out_valid),
    .data_o    (out_data),
    .last_o    (out_last),
    .free_o    (slot_free)
  );

  // R4
  esc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && reserved |=> !in_ready);

  // R3
  esc_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && reserved |=> out_valid && out_data == MARKER && !out_last);

  // R4
  no_fill_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data != FILL);
endmodule

// File: rtl/escape_decoder.sv
module escape_decoder
  import stuff_pkg::*;
#(
  parameter int unsigned     W      = 8,
  parameter logic [W-1:0]    MARKER = MARKER_DEF,
  parameter logic [W-1:0]    FILL   = FILL_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         err
);
  dec_phase_e   phase_q, phase_d;
  logic         err_d;
  logic         slot_free, in_fire, is_marker, is_fill, load;
  logic [W-1:0] load_data;

  assign is_marker = (in_data == MARKER);
  assign is_fill   = (in_data == FILL);
  assign in_ready  = slot_free;
  assign in_fire   = in_valid && in_ready;

  always_comb begin
    load      = 1'b0;
    load_data = in_data;
    phase_d   = phase_q;
    err_d     = 1'b0;
    if (in_fire) begin
      if (phase_q == DEC_ESCAPED) begin
        load      = 1'b1;
        load_data = in_data ^ MARKER;
        phase_d   = DEC_PLAIN;
      end else if (is_marker) begin
        if (in_last) err_d   = 1'b1;
        else         phase_d = DEC_ESCAPED;
      end else if (!is_fill) begin
        load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= DEC_PLAIN;
      err     <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err     <= err_d;
    end
  end

  beat_hold #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .load_last (in_last),
    .ready_i   (out_ready),
    .valid_o   (out_valid),
    .data_o    (out_data),
    .last_o    (out_last),
    .free_o    (slot_free)
  );

  // R6 R8
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && phase_q == DEC_PLAIN && (is_marker || is_fill) |=> !out_valid);

  // R6
  esc_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && phase_q == DEC_ESCAPED |=> out_valid);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);
endmodule

// File: rtl/stuff_codec.sv
module stuff_codec
  import stuff_pkg::*;
#(
  parameter int unsigned        BYTE_W      = 8,
  parameter int unsigned        SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0]  MARKER      = MARKER_DEF,
  parameter logic [BYTE_W-1:0]  FILL        = FILL_DEF
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [BYTE_W-1:0] enc_in_data,
  input  logic              enc_in_last,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [BYTE_W-1:0] enc_out_data,
  output logic              enc_out_last,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [BYTE_W-1:0] dec_in_data,
  input  logic              dec_in_last,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [BYTE_W-1:0] dec_out_data,
  output logic              dec_out_last,
  output logic              dec_err
);
  logic rst_n;

  rst_release #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  escape_encoder #(.W(BYTE_W), .MARKER(MARKER), .FILL(FILL)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_in_data),
    .in_last   (enc_in_last),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_data),
    .out_last  (enc_out_last)
  );

  escape_decoder #(.W(BYTE_W), .MARKER(MARKER), .FILL(FILL)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   (dec_in_data),
    .in_last   (dec_in_last),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_out_data),
    .out_last  (dec_out_last),
    .err       (dec_err)
  );
endmodule

// File: tb/test_stuff_codec.sv
`timescale 1ns/1ps
module test_stuff_codec;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic arst_n;
  logic enc_in_valid, enc_in_ready, enc_in_last;
  logic [7:0] enc_in_data;
  logic enc_out_valid, enc_out_ready, enc_out_last;
  logic [7:0] enc_out_data;
  logic dec_in_valid, dec_in_ready, dec_in_last;
  logic [7:0] dec_in_data;
  logic dec_out_valid, dec_out_ready, dec_out_last, dec_err;
  logic [7:0] dec_out_data;

  logic loop, e_rdy, thr_e, thr_d;
  logic d_valid, d_last;
  logic [7:0] d_data;

  assign enc_out_ready = loop ? dec_in_ready : e_rdy;
  assign dec_in_valid  = loop ? enc_out_valid : d_valid;
  assign dec_in_data   = loop ? enc_out_data  : d_data;
  assign dec_in_last   = loop ? enc_out_last  : d_last;

  stuff_codec i_stuff_codec (
    .clk(clk), .arst_n(arst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
    .enc_in_data(enc_in_data), .enc_in_last(enc_in_last),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
    .enc_out_data(enc_out_data), .enc_out_last(enc_out_last),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready),
    .dec_in_data(dec_in_data), .dec_in_last(dec_in_last),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
    .dec_out_data(dec_out_data), .dec_out_last(dec_out_last),
    .dec_err(dec_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int err_cnt = 0;
  bit [8:0] eq[$], dq[$], exp_q[$];
  int et[$];
  bit e_hold, d_hold, e_res;
  bit [8:0] e_beat, d_beat;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    e_rdy = thr_e ? ((cyc % 3) != 1) : 1'b1;
    dec_out_ready = thr_d ? ((cyc % 5) != 2) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: samples at negedge, values stable until the next posedge
  always @(negedge clk) begin
    if (arst_n) begin
      if (e_hold) check(enc_out_valid && {enc_out_last, enc_out_data} == e_beat,
                        "R10 enc hold", {enc_out_last, enc_out_data}, e_beat);
      if (d_hold) check(dec_out_valid && {dec_out_last, dec_out_data} == d_beat,
                        "R10 dec hold", {dec_out_last, dec_out_data}, d_beat);
      if (e_res) check(!enc_in_ready, "R4 ready bubble", enc_in_ready, 0);
      e_hold = enc_out_valid && !enc_out_ready;
      e_beat = {enc_out_last, enc_out_data};
      d_hold = dec_out_valid && !dec_out_ready;
      d_beat = {dec_out_last, dec_out_data};
      e_res  = enc_in_valid && enc_in_ready && (enc_in_data == 8'h55 || enc_in_data == 8'hAA);
      if (enc_out_valid && enc_out_ready) begin
        eq.push_back({enc_out_last, enc_out_data});
        et.push_back(cyc);
      end
      if (dec_out_valid && dec_out_ready) dq.push_back({dec_out_last, dec_out_data});
      if (dec_err) err_cnt++;
    end
  end

  task automatic enc_push(input logic [7:0] d, input logic l);
    enc_in_valid = 1'b1; enc_in_data = d; enc_in_last = l;
    do @(negedge clk); while (!enc_in_ready);
    @(posedge clk); #1;
    enc_in_valid = 1'b0;
  endtask

  task automatic dec_push(input logic [7:0] d, input logic l);
    d_valid = 1'b1; d_data = d; d_last = l;
    do @(negedge clk); while (!dec_in_ready);
    @(posedge clk); #1;
    d_valid = 1'b0;
  endtask

  task automatic exp_enc(input logic [7:0] d, input logic l);
    if (d == 8'h55 || d == 8'hAA) begin
      exp_q.push_back({1'b0, 8'h55});
      exp_q.push_back({l, d ^ 8'h55});
    end else exp_q.push_back({l, d});
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmp(input string req, ref bit [8:0] act[$]);
    check(act.size() == exp_q.size(), {req, " count"}, act.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < act.size(); i++)
      check(act[i] == exp_q[i], req, act[i], exp_q[i]);
    act.delete();
    exp_q.delete();
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    arst_n = 1'b0; loop = 1'b0; e_rdy = 1'b1; dec_out_ready = 1'b1;
    thr_e = 1'b0; thr_d = 1'b0;
    enc_in_valid = 1'b0; enc_in_data = '0; enc_in_last = 1'b0;
    d_valid = 1'b0; d_data = '0; d_last = 1'b0;
    idle(3);
    arst_n = 1'b1;
    idle(4);
    // R1 reset state
    check(!enc_out_valid && !dec_out_valid && !dec_err, "R1 outputs idle",
          {enc_out_valid, dec_out_valid, dec_err}, 0);
    check(enc_in_ready && dec_in_ready, "R1 readies", {enc_in_ready, dec_in_ready}, 3);

    // R2 R3: full sweep, sink always ready
    for (int i = 0; i < 256; i++) begin
      enc_push(i[7:0], i == 255);
      exp_enc(i[7:0], i == 255);
    end
    idle(10);
    cmp("R2 R3 sweep", eq);
    et.delete();

    // R5: burst of reserved bytes at full rate
    for (int i = 0; i < 8; i++) begin
      enc_push(i[0] ? 8'hAA : 8'h55, i == 7);
      exp_enc(i[0] ? 8'hAA : 8'h55, i == 7);
    end
    idle(10);
    check(et.size() == 16, "R5 burst length", et.size(), 16);
    if (et.size() == 16) check(et[15] - et[0] == 15, "R5 burst cycles", et[15] - et[0], 15);
    cmp("R3 R5 burst data", eq);
    et.delete();

    // R10: sweep with throttled sink
    thr_e = 1'b1;
    for (int i = 0; i < 256; i++) begin
      enc_push(8'(255 - i), (i % 16) == 15);
      exp_enc(8'(255 - i), (i % 16) == 15);
    end
    idle(20);
    thr_e = 1'b0;
    cmp("R10 throttled sweep", eq);
    et.delete();

    // R11: loopback round trip with throttled decoder sink
    loop = 1'b1; thr_d = 1'b1;
    for (int i = 0; i < 256; i++) begin
      enc_push(i[7:0], (i % 32) == 31);
      exp_q.push_back({(i % 32) == 31, i[7:0]});
    end
    idle(30);
    thr_d = 1'b0;
    cmp("R11 round trip", dq);
    loop = 1'b0;
    eq.delete(); et.delete();
    idle(2);

    // R7 plain pass-through
    dec_push(8'h12, 1'b0); dec_push(8'h34, 1'b1);
    exp_q.push_back({1'b0, 8'h12}); exp_q.push_back({1'b1, 8'h34});
    idle(4);
    cmp("R7 pass", dq);

    // R6 escapes
    dec_push(8'h55, 1'b0); dec_push(8'hFF, 1'b0);
    dec_push(8'h55, 1'b0); dec_push(8'h00, 1'b1);
    dec_push(8'h55, 1'b0); dec_push(8'hAA, 1'b0);
    exp_q.push_back({1'b0, 8'hAA}); exp_q.push_back({1'b1, 8'h55});
    exp_q.push_back({1'b0, 8'hFF});
    idle(4);
    cmp("R6 escape", dq);

    // R8 fill dropped
    dec_push(8'hAA, 1'b0); dec_push(8'h42, 1'b0); dec_push(8'hAA, 1'b1);
    exp_q.push_back({1'b0, 8'h42});
    idle(4);
    cmp("R8 fill", dq);
    check(err_cnt == 0, "R8 no error", err_cnt, 0);

    // R9 dangling marker
    dec_push(8'h55, 1'b1);
    idle(4);
    check(err_cnt == 1, "R9 error pulse", err_cnt, 1);
    check(dq.size() == 0, "R9 no output", dq.size(), 0);
    dec_push(8'h66, 1'b1);
    exp_q.push_back({1'b1, 8'h66});
    idle(4);
    cmp("R9 recovery", dq);
    check(err_cnt == 1, "R9 single pulse", err_cnt, 1);

    summary();
  end
endmodule